// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block supervises a host by watching a serial-bus chip-select line that also acts as its service input. Each time the host drives the line low for long enough, the timeout count starts again. If the line sits at one level, high or low, for longer than the selected period, the block raises a one-cycle timeout pulse. It also drives a reset level for a fixed hold interval, which a downstream reset generator consumes.

A 2-bit period code chooses the timeout period. Code 00 selects the long period (nominally 1.4 s), code 01 the middle period (nominally 600 ms) and code 10 the short period (nominally 200 ms). Code 11 turns the watchdog off, and it is the value the block assumes out of reset. All periods are counted in ticks of one prescaler whose length is a parameter, so simulation can shrink them. The defaults assume a 1 ms tick at 50 MHz.

The service line passes through a two-flop synchroniser before any decision is taken on it. A low level counts as a service only after the synchronised line has stayed low for a minimum number of clock cycles. That minimum is nominally 400 ns.

Top module: `edge_wdt`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `wdt_fire` and `wdt_reset` are 0. The period register comes out of reset holding code 11 (off).
- R2: With no service, the period code selects the limit: 00 gives TICKS_LONG, 01 gives TICKS_MID and 10 gives TICKS_SHORT, each in ticks of CLK_PER_TICK cycles. The timeout fires after the selected limit.
- R3: While the registered period code is 11, `wdt_fire` never rises and the count stays at zero.
- R4: The count restarts when the synchronised service line has been low for MIN_LOW_CYC consecutive cycles. A host that does this more often than the period never sees a timeout.
- R5: A low pulse shorter than MIN_LOW_CYC synchronised cycles is not a service and leaves the count running.
- R6: A service line held permanently low causes repeated timeouts, just as one held permanently high does.
- R7: `wdt_fire` lasts exactly one cycle. `wdt_reset` rises in the same cycle and stays high for RESET_TICKS*CLK_PER_TICK cycles.
- R8: The count is held at zero while `wdt_reset` is high. With no service, successive timeouts are therefore spaced by the period plus the hold interval.
- R9: Any change of `period_sel` restarts the count from zero. The new period is then measured from the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_n | input | 1 | Chip-select line used as the service input, asynchronous |
| period_sel | input | 2 | Period code: 00 long, 01 middle, 10 short, 11 off |
| wdt_fire | output | 1 | One-cycle timeout event |
| wdt_reset | output | 1 | Reset level held for the hold interval after a timeout |

## Verification
The bench goes after the minimum-low boundary: pulses one cycle shorter than the minimum must let the timeout through, and pulses exactly at the minimum must hold it off. A design that restarts on the raw falling edge would swallow the short pulses, and an off-by-one filter would miss the exact ones. It holds the line low forever to catch a design that treats a steady low as continuous service. It measures the spacing of back-to-back timeouts to expose a counter that keeps running during the hold interval. It also switches the period code mid-count to expose a design that carries the old count into the new period and so fires early or very late.

// File: rtl/ewdt_pkg.sv
package ewdt_pkg;

    typedef enum logic [1:0] {
        PER_LONG  = 2'b00,
        PER_MID   = 2'b01,
        PER_SHORT = 2'b10,
        PER_OFF   = 2'b11
    } per_sel_e;

    typedef struct packed {
        logic level;   // synchronised service line
        logic accept;  // one-cycle valid service
    } svc_stat_t;

    typedef struct packed {
        logic fire;    // one-cycle timeout event
        logic hold;    // stretched reset level
    } rst_out_t;

    function automatic int unsigned sel_ticks(per_sel_e s, int unsigned t_long,
                                              int unsigned t_mid, int unsigned t_short);
        case (s)
            PER_LONG:  return t_long;
            PER_MID:   return t_mid;
            PER_SHORT: return t_short;
            default:   return 0;
        endcase
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ewdt_svc_filter.sv
module ewdt_svc_filter
    import ewdt_pkg::*;
#(
    parameter int unsigned MIN_LOW = 20
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      svc_raw,
    output svc_stat_t stat
);
    localparam int unsigned LW = $clog2(MIN_LOW + 1);

    logic [1:0]    sync_q;
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            low_run <= '0;
        end else begin
            sync_q <= {sync_q[0], svc_raw};
            if (sync_q[1])
                low_run <= '0;
            else if (low_run != LW'(MIN_LOW))
                low_run <= low_run + 1'b1;
        end
    end

    assign stat.level  = sync_q[1];
    assign stat.accept = !sync_q[1] && (low_run == LW'(MIN_LOW - 1));

    // R5: a service needs a low run, so the line was already low a cycle earlier
    a_r5_low_before_accept: assert property (@(posedge clk) disable iff (rst)
        stat.accept |-> $past(stat.level == 1'b0));

    // R4: an accepted service is reported once per low run
    a_r4_single_accept: assert property (@(posedge clk) disable iff (rst)
        stat.accept |=> !stat.accept);

endmodule

// File: rtl/ewdt_interval.sv
module ewdt_interval
    import ewdt_pkg::*;
#(
    parameter int unsigned TICK_CYC = 50000,
    parameter int unsigned T_LONG   = 1400,
    parameter int unsigned T_MID    = 600,
    parameter int unsigned T_SHORT  = 200
) (
    input  logic     clk,
    input  logic     rst,
    input  per_sel_e sel_q,
    input  logic     restart,
    output logic     expire
);
    localparam int unsigned PW   = $clog2(TICK_CYC + 1);
    localparam int unsigned TMAX = max3(T_LONG, T_MID, T_SHORT);
    localparam int unsigned TW   = $clog2(TMAX + 1);

    logic [PW-1:0] pre;
    logic [TW-1:0] tk;
    logic [TW-1:0] lim_m1;
    logic          pre_end;

    always_comb begin
        lim_m1  = TW'(sel_ticks(sel_q, T_LONG, T_MID, T_SHORT)) - 1'b1;
        pre_end = (pre == PW'(TICK_CYC - 1));
        expire  = !restart && pre_end && (tk == lim_m1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart || expire) begin
            pre <= '0;
            tk  <= '0;
        end else if (pre_end) begin
            pre <= '0;
            tk  <= tk + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // R2: tick count never passes the longest period
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        tk <= TW'(TMAX));

    // R8: a restart leaves the whole count at zero
    a_r8_cleared_after_restart: assert property (@(posedge clk) disable iff (rst)
        $past(restart) |-> (pre == '0 && tk == '0));

endmodule

// File: rtl/ewdt_reset_stretch.sv
module ewdt_reset_stretch
    import ewdt_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 10000000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     expire,
    output rst_out_t ro
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] hc;

    always_ff @(posedge clk) begin
        if (rst) begin
            ro <= '0;
            hc <= '0;
        end else begin
            ro.fire <= expire;
            if (expire) begin
                ro.hold <= 1'b1;
                hc      <= HW'(HOLD_CYC - 1);
            end else if (ro.hold) begin
                if (hc == '0)
                    ro.hold <= 1'b0;
                else
                    hc <= hc - 1'b1;
            end
        end
    end

    // R7: the timeout event is a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ro.fire |=> !ro.fire);

    // R7: reset level only starts together with a timeout event
    a_r7_rise_with_fire: assert property (@(posedge clk) disable iff (rst)
        $rose(ro.hold) |-> ro.fire);

endmodule

// File: rtl/edge_wdt.sv
module edge_wdt
    import ewdt_pkg::*;
#(
    parameter int unsigned CLK_PER_TICK = 50000,
    parameter int unsigned TICKS_LONG   = 1400,
    parameter int unsigned TICKS_MID    = 600,
    parameter int unsigned TICKS_SHORT  = 200,
    parameter int unsigned RESET_TICKS  = 200,
    parameter int unsigned MIN_LOW_CYC  = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       svc_n,
    input  logic [1:0] period_sel,
    output logic       wdt_fire,
    output logic       wdt_reset
);
    localparam int unsigned HOLD_CYC = RESET_TICKS * CLK_PER_TICK;

    per_sel_e  sel_q;
    svc_stat_t svc;
    rst_out_t  ro;
    logic      code_chg;
    logic      restart;
    logic      expire;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= PER_OFF;
        else     sel_q <= per_sel_e'(period_sel);
    end

    assign code_chg = (per_sel_e'(period_sel) != sel_q);
    assign restart  = svc.accept || code_chg || (sel_q == PER_OFF) || ro.hold;

    ewdt_svc_filter #(.MIN_LOW(MIN_LOW_CYC)) i_filter (
        .clk(clk), .rst(rst), .svc_raw(svc_n), .stat(svc)
    );

    ewdt_interval #(
        .TICK_CYC(CLK_PER_TICK), .T_LONG(TICKS_LONG),
        .T_MID(TICKS_MID), .T_SHORT(TICKS_SHORT)
    ) i_interval (
        .clk(clk), .rst(rst), .sel_q(sel_q), .restart(restart), .expire(expire)
    );

    ewdt_reset_stretch #(.HOLD_CYC(HOLD_CYC)) i_stretch (
        .clk(clk), .rst(rst), .expire(expire), .ro(ro)
    );

    assign wdt_fire  = ro.fire;
    assign wdt_reset = ro.hold;

    // R3: an off code in the previous cycle means no event now
    a_r3_off_silent: assert property (@(posedge clk) disable iff (rst)
        $past(sel_q == PER_OFF) |-> !wdt_fire);

    // R9: a code change in the previous cycle blocks an event now
    a_r9_change_restarts: assert property (@(posedge clk) disable iff (rst)
        $past(code_chg) |-> !wdt_fire);

    // R8: no new event while the reset level from the last one is held
    a_r8_no_fire_in_hold: assert property (@(posedge clk) disable iff (rst)
        $past(wdt_reset) && wdt_reset |-> !wdt_fire);

endmodule

// File: tb/test_edge_wdt.sv
module test_edge_wdt;
    localparam int TCK = 3, TL = 10, TM = 6, TS = 3, RT = 2, ML = 4;
    localparam int HOLD = RT * TCK;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic svc_n = 1'b1;
    logic [1:0] period_sel = 2'b11;
    logic wdt_fire, wdt_reset;

    always #10 clk = ~clk;

    edge_wdt #(
        .CLK_PER_TICK(TCK), .TICKS_LONG(TL), .TICKS_MID(TM),
        .TICKS_SHORT(TS), .RESET_TICKS(RT), .MIN_LOW_CYC(ML)
    ) i_edge_wdt (
        .clk(clk), .rst(rst), .svc_n(svc_n), .period_sel(period_sel),
        .wdt_fire(wdt_fire), .wdt_reset(wdt_reset)
    );

    int vectors = 0, errors = 0, cyc = 0;
    bit done = 0;

    function automatic int lim_cycles(int code);
        case (code)
            0: return TL * TCK;
            1: return TM * TCK;
            2: return TS * TCK;
            default: return 0;
        endcase
    endfunction

    // behavioural reference model
    int m_s1 = 1, m_s2 = 1, m_low = 0, m_code = 3, m_cnt = 0, m_hc = 0;
    bit m_fire = 0, m_act = 0;
    always @(posedge clk) begin
        bit acc, rs, ex;
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_low = 0; m_code = 3; m_cnt = 0;
            m_fire = 0; m_act = 0; m_hc = 0;
        end else begin
            acc = (m_s2 == 0) && (m_low == ML - 1);
            rs  = acc || (int'(period_sel) != m_code) || (m_code == 3) || m_act;
            ex  = !rs && (m_cnt == lim_cycles(m_code) - 1);
            m_low = (m_s2 != 0) ? 0 : ((m_low < ML) ? m_low + 1 : m_low);
            m_s2 = m_s1;
            m_s1 = int'(svc_n);
            m_cnt = (rs || ex) ? 0 : m_cnt + 1;
            if (ex) begin
                m_act = 1; m_hc = HOLD - 1;
            end else if (m_act) begin
                if (m_hc == 0) m_act = 0;
                else m_hc = m_hc - 1;
            end
            m_fire = ex;
            m_code = int'(period_sel);
        end
    end

    // per-cycle comparison and event bookkeeping
    int fire_count = 0, last_fire = 0, prev_fire = 0;
    int rst_run = 0, last_rst_len = 0, fire_run = 0, fire_max = 0;
    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            vectors++;
            if (wdt_fire !== m_fire || wdt_reset !== m_act) begin
                errors++;
                $display("FAIL R7 cycle model: fire/reset actual %b%b expected %b%b at cycle %0d",
                         wdt_fire, wdt_reset, m_fire, m_act, cyc);
            end
        end
        if (wdt_fire) begin
            fire_count++; prev_fire = last_fire; last_fire = cyc;
            fire_run++; if (fire_run > fire_max) fire_max = fire_run;
        end else fire_run = 0;
        if (wdt_reset) rst_run++;
        else if (rst_run > 0) begin last_rst_len = rst_run; rst_run = 0; end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_fires(int n);
        int base = fire_count;
        int guard = 0;
        while (fire_count < base + n && guard < 2000) begin
            @(negedge clk); guard++;
        end
    endtask

    task automatic wait_no_reset();
        @(negedge clk);
        while (wdt_reset) @(negedge clk);
    endtask

    task automatic service_train(int reps, int hi, int lo);
        for (int i = 0; i < reps; i++) begin
            svc_n = 1'b1; repeat (hi) @(negedge clk);
            svc_n = 1'b0; repeat (lo) @(negedge clk);
        end
        svc_n = 1'b1;
    endtask

    initial begin
        int base, c0;
        repeat (4) @(negedge clk);
        check(wdt_fire == 0 && wdt_reset == 0, "R1 outputs in reset", {wdt_fire, wdt_reset}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(wdt_fire == 0 && wdt_reset == 0, "R1 outputs after reset", {wdt_fire, wdt_reset}, 0);

        // R3 / R1: off code, no service, stays silent
        repeat (150) @(negedge clk);
        check(fire_count == 0, "R3 off code silent", fire_count, 0);

        // R2 / R8 / R7: each code, line held high
        period_sel = 2'b00; wait_fires(3);
        check(last_fire - prev_fire == TL * TCK + HOLD, "R2 R8 long spacing", last_fire - prev_fire, TL * TCK + HOLD);
        check(fire_max == 1, "R7 fire width", fire_max, 1);
        wait_no_reset();
        check(last_rst_len == HOLD, "R7 reset width", last_rst_len, HOLD);
        period_sel = 2'b01; wait_fires(3);
        check(last_fire - prev_fire == TM * TCK + HOLD, "R2 R8 middle spacing", last_fire - prev_fire, TM * TCK + HOLD);
        period_sel = 2'b10; wait_fires(3);
        check(last_fire - prev_fire == TS * TCK + HOLD, "R2 R8 short spacing", last_fire - prev_fire, TS * TCK + HOLD);

        // R6: line held low still times out
        svc_n = 1'b0; wait_fires(3);
        check(last_fire - prev_fire == TS * TCK + HOLD, "R6 held low spacing", last_fire - prev_fire, TS * TCK + HOLD);
        svc_n = 1'b1;

        // R4: regular valid services, including the exact minimum
        period_sel = 2'b00; wait_no_reset();
        base = fire_count;
        service_train(12, 15, 5);
        check(fire_count == base, "R4 serviced no timeout", fire_count - base, 0);
        base = fire_count;
        service_train(12, 16, ML);
        check(fire_count == base, "R4 minimum low serviced", fire_count - base, 0);

        // R5: pulses one cycle too short do not service
        base = fire_count;
        service_train(15, 15, ML - 1);
        check(fire_count > base, "R5 short pulses ignored", fire_count - base, 1);

        // R9: code change restarts count
        wait_no_reset();
        repeat (20) @(negedge clk);
        base = fire_count;
        c0 = cyc;
        period_sel = 2'b10;
        wait_fires(1);
        check(fire_count == base + 1 && (last_fire - c0) >= TS * TCK && (last_fire - c0) <= TS * TCK + 4,
              "R9 restart on change", last_fire - c0, TS * TCK + 2);

        // R3: switching off mid-count suppresses events
        wait_no_reset();
        period_sel = 2'b11;
        base = fire_count;
        repeat (100) @(negedge clk);
        check(fire_count == base, "R3 off after running", fire_count - base, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule